// File: doc/BRIEF.md
# Hybrid Counter / Sigma-Delta Pulse-Width Modulator

This block turns an 11-bit duty command into the switching waveform for a synchronous step-down converter. The upper duty bits set a coarse pulse width. That width is compared against a free-running 5-bit period counter, so each switching period lasts 32 system clocks. The lower duty bits feed a first-order sigma-delta accumulator. Its overflow stretches the pulse by one clock in some periods. Over 64 periods, the total high time therefore equals the full duty value in clocks.

The two drive outputs are complementary while the block runs. There is no dead time between them. When the enable is low, both outputs are held low, the accumulator is cleared, and the power-on flag is low. The duty command is captured only at the start of each period, so a change in the middle of a period never alters the pulse already in progress.

Top module: `hsdpwm`

## Requirements
- R1: After reset, or while `en` is low, `drvHigh`, `drvLow` and `powerOn` are all 0.
- R2: `powerOn` goes high on the first clock edge that samples `en` high. It stays high while `en` stays high, and it drops on the first edge that samples `en` low. A switching period is exactly 32 clocks long, and the first period starts in the cycle in which `powerOn` first reads 1.
- R3: The coarse field is `duty[10:6]` and the fine field is `duty[5:0]`. Inside a period, `drvHigh` is 1 for the first W clocks and 0 for the rest. W is the coarse field, plus 1 when the accumulator overflows at that period's start.
- R4: While `powerOn` is 1, exactly one of `drvHigh` and `drvLow` is 1.
- R5: Hold `duty` constant from enable onward. Over the first 64 periods, `drvHigh` is high for exactly `duty` clocks in total.
- R6: A duty of 0 never raises `drvHigh`. A coarse field of 31 with an overflow gives a period that is high for all 32 clocks; the value saturates and does not wrap to a short pulse.
- R7: A change of `duty` in the middle of a period has no effect on that period. The new value is taken at the next period start.
- R8: Disabling clears the accumulator. After re-enabling, the pulse sequence restarts as if from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both drives off |
| duty | input | 11 | Duty command: coarse field in the upper 5 bits, fine field in the lower 6 |
| drvHigh | output | 1 | High-side switch conduct command |
| drvLow | output | 1 | Low-side switch conduct command |
| powerOn | output | 1 | Switching is active |

## Verification
The assertions assume that `en` and `duty` change only between clock edges. They also assume that a period begins only at an enable rising edge or at a counter wrap. The checker therefore keeps its own period-position counter, which it aligns to the rise of `powerOn`. The bench drives every input on the falling clock edge. Each measurement starts from a disabled state, so every measured window is aligned to a fresh period start.

// File: rtl/hsdpwm_pkg.sv
package hsdpwm_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;  // drop accumulator and compare value
    logic load;   // period start: sample duty, step modulator
  } ctlStrobes_t;
endpackage

// File: rtl/hsdpwm_ctrl.sv
module hsdpwm_ctrl
  import hsdpwm_pkg::*;
#(
  parameter int COARSE_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  output ctlStrobes_t         strobes,
  output logic [COARSE_W-1:0] cnt,
  output logic                run
);
  localparam logic [COARSE_W-1:0] CNT_LAST = '1;

  logic periodStart;
  assign periodStart = en && (!run || (cnt == CNT_LAST));

  always_comb begin
    strobes.clear = !en;
    strobes.load  = periodStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (periodStart) begin
      run <= 1'b1;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hsdpwm_dp.sv
module hsdpwm_dp
  import hsdpwm_pkg::*;
#(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  strobes,
  input  logic [COARSE_W+FINE_W-1:0]   duty,
  input  logic [COARSE_W-1:0]          cnt,
  input  logic                         run,
  output logic                         drvHigh,
  output logic                         drvLow
);
  localparam int CMP_W = COARSE_W + 1;

  logic [FINE_W-1:0]   acc;
  logic [CMP_W-1:0]    cmpVal;
  logic [FINE_W:0]     accSum;
  logic [COARSE_W-1:0] coarseField;
  logic [FINE_W-1:0]   fineField;
  logic                pulse;

  assign coarseField = duty[COARSE_W+FINE_W-1:FINE_W];
  assign fineField   = duty[FINE_W-1:0];
  assign accSum      = {1'b0, acc} + {1'b0, fineField};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      cmpVal <= '0;
    end else if (strobes.clear) begin
      acc    <= '0;
      cmpVal <= '0;
    end else if (strobes.load) begin
      acc    <= accSum[FINE_W-1:0];
      // the compare value is one bit wider than the counter, so coarse max plus carry fits
      cmpVal <= {1'b0, coarseField} + {{(CMP_W-1){1'b0}}, accSum[FINE_W]};
    end
  end

  assign pulse   = ({1'b0, cnt} < cmpVal);
  assign drvHigh = run && pulse;
  assign drvLow  = run && !pulse;
endmodule

// File: rtl/hsdpwm.sv
module hsdpwm
  import hsdpwm_pkg::*;
#(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       en,
  input  logic [COARSE_W+FINE_W-1:0] duty,
  output logic                       drvHigh,
  output logic                       drvLow,
  output logic                       powerOn
);
  ctlStrobes_t         strobes;
  logic [COARSE_W-1:0] cnt;
  logic                run;

  hsdpwm_ctrl #(.COARSE_W(COARSE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .en(en),
    .strobes(strobes), .cnt(cnt), .run(run)
  );

  hsdpwm_dp #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .duty(duty),
    .cnt(cnt), .run(run), .drvHigh(drvHigh), .drvLow(drvLow)
  );

  assign powerOn = run;
endmodule

// File: rtl/hsdpwm_chk.sv
module hsdpwm_chk #(
  parameter int COARSE_W = 5
) (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic drvHigh,
  input logic drvLow,
  input logic powerOn
);
  logic [COARSE_W-1:0] posCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        posCnt <= '0;
    else if (powerOn) posCnt <= posCnt + 1'b1;
    else              posCnt <= '0;
  end

  // R1: the drives stay quiet while not running
  a_r1_off_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |-> (!drvHigh && !drvLow));

  // R2: enable is followed by power-on
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    en |=> powerOn);

  // R2: disable is followed by power-off
  a_r2_stop: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !powerOn);

  // R4: the two drives are complementary while running
  a_r4_complementary: assert property (@(posedge clk) disable iff (!rstN)
    powerOn |-> ($countones({drvHigh, drvLow}) == 1));

  // R3: the pulse never rises inside a period
  a_r3_no_mid_rise: assert property (@(posedge clk) disable iff (!rstN)
    (powerOn && (posCnt != '0) && $past(powerOn) && !$past(drvHigh)) |-> !drvHigh);
endmodule

bind hsdpwm hsdpwm_chk #(.COARSE_W(COARSE_W)) u_chk (
  .clk(clk), .rstN(rstN), .en(en),
  .drvHigh(drvHigh), .drvLow(drvLow), .powerOn(powerOn)
);

// File: tb/hsdpwm_bench.sv
module hsdpwm_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [10:0] duty = '0;
  logic        drvHigh, drvLow, powerOn;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  bit mRun = 0;
  int mCnt = 0;
  int mAcc = 0;
  int mCmp = 0;

  always #4 clk = ~clk;

  hsdpwm u_hsdpwm (
    .clk(clk), .rstN(rstN), .en(en), .duty(duty),
    .drvHigh(drvHigh), .drvLow(drvLow), .powerOn(powerOn)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN || !en) begin
      mRun = 0; mCnt = 0; mAcc = 0; mCmp = 0;
    end else if (!mRun || mCnt == 31) begin
      int s;
      s    = mAcc + int'(duty[5:0]);
      mCmp = int'(duty[10:6]) + ((s >= 64) ? 1 : 0);
      mAcc = s % 64;
      mCnt = 0;
      mRun = 1;
    end else begin
      mCnt = mCnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R1, R3, R4)
  always @(negedge clk) begin
    if (rstN) begin
      bit eh;
      eh = mRun && (mCnt < mCmp);
      check("R3 drvHigh", int'(drvHigh), int'(eh));
      check("R4 drvLow", int'(drvLow), int'(mRun && !eh));
      check("R1 powerOn", int'(powerOn), int'(mRun));
    end
  end

  task automatic restart(input logic [10:0] d);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    @(negedge clk); duty = d; en = 1'b1;
  endtask

  task automatic countHigh(input int periods, output int total);
    total = 0;
    for (int i = 0; i < periods * 32; i++) begin
      @(negedge clk);
      total += int'(drvHigh);
    end
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    check("R1 reset drvHigh", int'(drvHigh), 0);
    check("R1 reset drvLow", int'(drvLow), 0);
    check("R1 reset powerOn", int'(powerOn), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 disabled powerOn", int'(powerOn), 0);

    // R6: zero duty
    restart(11'd0);
    countHigh(4, t);
    check("R6 zero duty total", t, 0);
    check("R2 powerOn while enabled", int'(powerOn), 1);

    // R5 / R6: full-scale duty, the carry period is 32 clocks high
    restart(11'd2047);
    countHigh(64, t);
    check("R5 full-scale total", t, 2047);

    // R6: the second period has acc 63+63 overflow giving 32 high
    restart(11'd2047);
    countHigh(1, t);
    check("R6 first period", t, 31);
    countHigh(1, t);
    check("R6 saturated period", t, 32);

    restart(11'd100);
    countHigh(64, t);
    check("R5 duty 100 total", t, 100);

    restart(11'd1000);
    countHigh(64, t);
    check("R5 duty 1000 total", t, 1000);

    restart(11'd1234);
    countHigh(64, t);
    check("R5 duty 1234 total", t, 1234);

    // R2: period length, the second period starts high again after 32 clocks
    restart(11'd64);
    countHigh(1, t);
    check("R2 one period width", t, 1);
    @(negedge clk);
    check("R2 period restart", int'(drvHigh), 1);

    // R7: a mid-period change is ignored until the boundary
    restart(11'd320);
    t = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      t += int'(drvHigh);
      if (i == 2) duty = 11'd0;
    end
    check("R7 period kept old duty", t, 5);
    countHigh(1, t);
    check("R7 new duty at boundary", t, 0);

    // R8: a stale accumulator would give 2 here
    restart(11'd100);
    countHigh(10, t);
    restart(11'd100);
    countHigh(1, t);
    check("R8 accumulator cleared", t, 1);

    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R2 stop powerOn", int'(powerOn), 0);
    check("R1 disabled drvLow", int'(drvLow), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule